// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block drives a system reset from three causes. The first is power application, which a `por_n` input models. The second is a low-supply flag from an external comparator. The third is a watchdog that the host must service with bus activity. The host services the watchdog by issuing a START condition on a two-wire serial bus: SDA falls while SCL is high. No dedicated service pin is needed.

The reset is released only after the supply has stayed good for an uninterrupted hold interval. A watchdog timeout also holds the reset for one hold interval, then releases it and restarts the watchdog from zero. A two-bit selector picks one of three watchdog periods or switches the watchdog off. The selector is not cleared by power-up, so it models a setting that survives power cycles. It reads as undefined until the first write. The `wp` input locks the selector. All durations are counted in ticks of a prescaled timebase.

When the reset starts because of low supply or a timeout, the block gives a one-cycle abort strobe that ends any bus transfer in flight. A bus-inhibit flag stays high for as long as the reset is held. The flag blocks new bus transfers and blocks the start of new nonvolatile writes. A nonvolatile write that is already running is left to finish.

Top module: `sup_rst_wdog`

The controller has three states:
- `ST_LOW`: the supply is bad and reset is held.
- `ST_HOLD`: the supply is good and the hold interval is counting.
- `ST_RUN`: reset is released and the watchdog is counting.

The transitions are:
- `por_n` low forces `ST_LOW`.
- `ST_LOW` moves to `ST_HOLD` when the supply is good.
- `ST_HOLD` moves to `ST_LOW` on a supply drop, and to `ST_RUN` after `HOLD_TICKS` ticks.
- `ST_RUN` moves to `ST_LOW` on a supply drop, and to `ST_HOLD` on a watchdog expiry.

## Requirements
- R1: While `por_n` is low, reset is driven active, `bus_inhibit` is 1 and `bus_abort` is 0. Reset becomes active within one cycle of `por_n` falling.
- R2: After power-up with the supply good, reset is released no earlier than `(HOLD_TICKS-1)*PRESCALE` cycles and no later than `HOLD_TICKS*PRESCALE+6` cycles after `supply_ok` rises.
- R3: In `ST_RUN`, a low `supply_ok` activates reset 2 to 4 cycles later (two synchronizer stages plus the state register). In the same cycle, `bus_abort` pulses.
- R4: If the supply drops during the hold interval, the hold starts over. Release comes a full hold interval after the last recovery.
- R5: `stat_wd_sel` encodes the watchdog period: 00 selects `WD_TICKS0` ticks, 01 selects `WD_TICKS1`, 10 selects `WD_TICKS2`, and 11 disables the watchdog. Without service, reset activates between `(N-1)*PRESCALE` and `N*PRESCALE+6` cycles after release, where N is the selected tick count. With 11, no timeout occurs.
- R6: An SDA fall while SCL is high restarts the watchdog count from zero. An SDA fall while SCL is low does not.
- R7: A write (`cfg_we` high) loads `cfg_wdata` into `stat_wd_sel` on the next edge when `wp` is low. When `wp` is high, the write leaves `stat_wd_sel` unchanged.
- R8: `por_n` does not change `stat_wd_sel`.
- R9: `bus_abort` is a single-cycle pulse. It occurs only in the cycle in which reset activates from `ST_RUN`, never on power-up.
- R10: `bus_inhibit` is 1 exactly while reset is active.
- R11: With `RST_ACTIVE_HIGH`=0, `rst_out` is low while reset is active. With 1, it is high.
- R12: After a watchdog timeout, reset is held for between `(HOLD_TICKS-1)*PRESCALE` and `HOLD_TICKS*PRESCALE+3` cycles. It is then released, and the next timeout again takes the full selected period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-up indication, active low |
| supply_ok | input | 1 | Supply-above-threshold flag from the comparator (asynchronous) |
| sda | input | 1 | Serial data line (asynchronous) |
| scl | input | 1 | Serial clock line (asynchronous) |
| wp | input | 1 | Lock for the watchdog selector, high locks |
| cfg_we | input | 1 | Write strobe for the watchdog selector |
| cfg_wdata | input | 2 | New watchdog selector value |
| rst_out | output | 1 | System reset, polarity set by `RST_ACTIVE_HIGH` |
| bus_abort | output | 1 | One-cycle strobe ending the current bus transfer |
| bus_inhibit | output | 1 | Blocks new bus transfers and new nonvolatile writes |
| stat_wd_sel | output | 2 | Readback of the watchdog selector |

## Verification
A supply glitch in the middle of the hold interval must restart the hold. A design that keeps counting would release reset early, and the release-time window flags it. An SDA fall with SCL low must not service the watchdog. A design that treats it as a START would move the timeout well past its window.

Power-up must not raise the abort strobe. A design that strobes on every reset entry shows an extra event in the scoreboard. The locked write, the persistence of the selector through power-up, and the full-length period after a timeout restart are each checked. An implementation that clears the selector, or that fails to clear the watchdog count, misses the expected timing.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } sup_state_e;

    localparam logic [1:0] WDSEL_OFF = 2'b11;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) q <= RST_VAL;
                else        q <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) q <= RST_VAL;
                else        q <= g_stage[s-1].q;
            end
        end
    end

    assign d_out = g_stage[STAGES-1].q;
endmodule

// File: rtl/sup_tick.sv
module sup_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic por_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/sup_start_det.sv
module sup_start_det (
    input  logic clk,
    input  logic por_n,
    input  logic sda_s,
    input  logic scl_s,
    output logic start
);
    logic sda_prev_q;
    logic scl_prev_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sda_prev_q <= 1'b1;
            scl_prev_q <= 1'b1;
        end else begin
            sda_prev_q <= sda_s;
            scl_prev_q <= scl_s;
        end
    end

    assign start = sda_prev_q & ~sda_s & scl_prev_q & scl_s;
endmodule

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog
    import sup_pkg::*;
#(
    parameter bit RST_ACTIVE_HIGH = 1'b0,
    parameter int PRESCALE        = 4,
    parameter int HOLD_TICKS      = 8,
    parameter int WD_TICKS0       = 16,
    parameter int WD_TICKS1       = 32,
    parameter int WD_TICKS2       = 48
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       supply_ok,
    input  logic       sda,
    input  logic       scl,
    input  logic       wp,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    output logic       rst_out,
    output logic       bus_abort,
    output logic       bus_inhibit,
    output logic [1:0] stat_wd_sel
);
    localparam int WD_MAX01 = (WD_TICKS0 > WD_TICKS1) ? WD_TICKS0 : WD_TICKS1;
    localparam int WD_MAX   = (WD_MAX01 > WD_TICKS2) ? WD_MAX01 : WD_TICKS2;
    localparam int CW       = $clog2(WD_MAX + 1);
    localparam int HW       = $clog2(HOLD_TICKS + 1);

    logic [2:0] raw_in;
    logic [2:0] sync_in;
    logic       sda_s, scl_s, sup_s;
    logic       tick;
    logic       start;

    sup_state_e state_q, state_d;
    logic [HW-1:0] hold_q;
    logic [CW-1:0] wd_q;
    logic [1:0]    wd_sel_q;
    logic          rst_act_q;
    logic          abort_q;
    logic          wd_en;
    logic          hold_done;
    logic          wd_expire;
    logic [CW-1:0] wd_lim;

    assign raw_in = {supply_ok, scl, sda};

    sup_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_in  (raw_in),
        .d_out (sync_in)
    );

    assign sda_s = sync_in[0];
    assign scl_s = sync_in[1];
    assign sup_s = sync_in[2];

    sup_tick #(.DIV(PRESCALE)) u_tick (
        .clk   (clk),
        .por_n (por_n),
        .tick  (tick)
    );

    sup_start_det u_start (
        .clk   (clk),
        .por_n (por_n),
        .sda_s (sda_s),
        .scl_s (scl_s),
        .start (start)
    );

    // Watchdog selector: survives power-up, so no reset branch.
    always_ff @(posedge clk) begin
        if (cfg_we && !wp) wd_sel_q <= cfg_wdata;
    end

    always_comb begin
        unique case (wd_sel_q)
            2'b00:   wd_lim = CW'(WD_TICKS0);
            2'b01:   wd_lim = CW'(WD_TICKS1);
            2'b10:   wd_lim = CW'(WD_TICKS2);
            default: wd_lim = CW'(WD_MAX);
        endcase
    end

    assign wd_en     = (wd_sel_q != WDSEL_OFF);
    assign hold_done = tick && (hold_q == HW'(HOLD_TICKS - 1));
    assign wd_expire = wd_en && tick && !start && (wd_q >= wd_lim - 1'b1);

    // Hold interval counter, runs only in ST_HOLD.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 hold_q <= '0;
        else if (state_q != ST_HOLD) hold_q <= '0;
        else if (tick)              hold_q <= hold_q + 1'b1;
    end

    // Watchdog counter, cleared outside ST_RUN and on every START.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                                wd_q <= '0;
        else if (state_q != ST_RUN || start || !wd_en) wd_q <= '0;
        else if (tick && wd_q < CW'(WD_MAX))        wd_q <= wd_q + 1'b1;
    end

    // State register.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (sup_s) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!sup_s)         state_d = ST_LOW;
                else if (hold_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!sup_s)         state_d = ST_LOW;
                else if (wd_expire) state_d = ST_HOLD;
            end
            default: state_d = ST_LOW;
        endcase
    end

    // Output register: reset level and abort strobe.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_act_q <= 1'b1;
            abort_q   <= 1'b0;
        end else begin
            rst_act_q <= (state_d != ST_RUN);
            abort_q   <= (state_q == ST_RUN) && (state_d != ST_RUN);
        end
    end

    if (RST_ACTIVE_HIGH) begin : g_rst_hi
        assign rst_out = rst_act_q;
    end else begin : g_rst_lo
        assign rst_out = ~rst_act_q;
    end

    assign bus_abort   = abort_q;
    assign bus_inhibit = rst_act_q;
    assign stat_wd_sel = wd_sel_q;
endmodule

// File: rtl/sup_rst_wdog_chk.sv
module sup_rst_wdog_chk #(
    parameter bit RST_ACTIVE_HIGH = 1'b0,
    parameter int PRESCALE        = 4,
    parameter int HOLD_TICKS      = 8
) (
    input logic       clk,
    input logic       por_n,
    input logic       supply_ok,
    input logic       wp,
    input logic       cfg_we,
    input logic [1:0] cfg_wdata,
    input logic       rst_out,
    input logic       bus_abort,
    input logic       bus_inhibit,
    input logic [1:0] stat_wd_sel
);
    localparam logic [31:0] MIN_GOOD = 32'((HOLD_TICKS - 1) * PRESCALE);

    logic [1:0]  low_cnt_q;
    logic [31:0] good_cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_cnt_q  <= '0;
            good_cnt_q <= '0;
        end else begin
            if (supply_ok)              low_cnt_q <= '0;
            else if (low_cnt_q != 2'd3) low_cnt_q <= low_cnt_q + 1'b1;
            if (!supply_ok)                  good_cnt_q <= '0;
            else if (good_cnt_q != '1)       good_cnt_q <= good_cnt_q + 1'b1;
        end
    end

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        bus_abort |=> !bus_abort); // R9
    AST_ABORT_WITH_RESET: assert property (@(posedge clk) disable iff (!por_n)
        bus_abort |-> bus_inhibit); // R9
    AST_INHIBIT_TRACKS_RESET: assert property (@(posedge clk) disable iff (!por_n)
        bus_inhibit == (rst_out == RST_ACTIVE_HIGH)); // R10
    AST_WP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_we && wp) |=> $stable(stat_wd_sel)); // R7
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_we && !wp) |=> (stat_wd_sel == $past(cfg_wdata))); // R7
    AST_LOW_SUPPLY_RESETS: assert property (@(posedge clk) disable iff (!por_n)
        (low_cnt_q == 2'd3) |-> bus_inhibit); // R3
    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        $fell(bus_inhibit) |-> (good_cnt_q >= MIN_GOOD)); // R2
endmodule

bind sup_rst_wdog sup_rst_wdog_chk #(
    .RST_ACTIVE_HIGH (RST_ACTIVE_HIGH),
    .PRESCALE        (PRESCALE),
    .HOLD_TICKS      (HOLD_TICKS)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .supply_ok   (supply_ok),
    .wp          (wp),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .rst_out     (rst_out),
    .bus_abort   (bus_abort),
    .bus_inhibit (bus_inhibit),
    .stat_wd_sel (stat_wd_sel)
);

// File: tb/test_sup_rst_wdog.sv
module test_sup_rst_wdog;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 4;
    localparam int H          = 8;
    localparam int W0         = 16;
    localparam int W1         = 32;
    localparam int W2         = 48;
    localparam bit ACT_HIGH   = 1'b0;
    localparam int WDOG_LIMIT = 20000;

    localparam int EV_ASSERT  = 0;
    localparam int EV_RELEASE = 1;
    localparam int EV_ABORT   = 2;

    logic       clk = 1'b0;
    logic       por_n = 1'b1;
    logic       supply_ok = 1'b0;
    logic       sda = 1'b1;
    logic       scl = 1'b1;
    logic       wp = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic       rst_out;
    logic       bus_abort;
    logic       bus_inhibit;
    logic [1:0] stat_wd_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    sup_rst_wdog #(
        .RST_ACTIVE_HIGH (ACT_HIGH),
        .PRESCALE        (P),
        .HOLD_TICKS      (H),
        .WD_TICKS0       (W0),
        .WD_TICKS1       (W1),
        .WD_TICKS2       (W2)
    ) i_sup_rst_wdog (
        .clk         (clk),
        .por_n       (por_n),
        .supply_ok   (supply_ok),
        .sda         (sda),
        .scl         (scl),
        .wp          (wp),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .rst_out     (rst_out),
        .bus_abort   (bus_abort),
        .bus_inhibit (bus_inhibit),
        .stat_wd_sel (stat_wd_sel)
    );

    typedef struct { int kind; int cyc; } obs_t;
    typedef struct { int kind; int base; int lo; int hi; string req; } exp_t;

    obs_t obs_q[$];
    exp_t exp_q[$];
    obs_t cur_o;
    exp_t cur_e;
    int   cur_b;
    int   cur_d;
    bit   cur_act;
    bit   prev_act = 1'b1;
    bit   mon_en = 1'b0;
    int   ref_cyc = 0;
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string kname(input int k);
        if (k == EV_ASSERT)  return "assert";
        if (k == EV_RELEASE) return "release";
        return "abort";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor and scoreboard compare.
    always @(negedge clk) begin
        if (mon_en) begin
            cur_act = (rst_out == ACT_HIGH);
            if (cur_act && !prev_act) obs_q.push_back('{EV_ASSERT, cyc});
            if (!cur_act && prev_act) obs_q.push_back('{EV_RELEASE, cyc});
            if (bus_abort)            obs_q.push_back('{EV_ABORT, cyc});
            prev_act = cur_act;
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                cur_o = obs_q.pop_front();
                cur_e = exp_q.pop_front();
                cur_b = (cur_e.base < 0) ? ref_cyc : cur_e.base;
                cur_d = cur_o.cyc - cur_b;
                n_checks++;
                if (cur_o.kind != cur_e.kind || cur_d < cur_e.lo || cur_d > cur_e.hi) begin
                    n_fail++;
                    $display("FAIL %s: actual %s after %0d cycles, expected %s within [%0d,%0d]",
                             cur_e.req, kname(cur_o.kind), cur_d, kname(cur_e.kind),
                             cur_e.lo, cur_e.hi);
                end
                ref_cyc = cur_o.cyc;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc >= WDOG_LIMIT) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d, expected end before %0d", cyc, WDOG_LIMIT);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_ev(input int kind, input int base, input int lo,
                             input int hi, input string req);
        exp_q.push_back('{kind, base, lo, hi, req});
    endtask

    task automatic wr_cfg(input logic [1:0] val);
        step(1);
        cfg_we = 1'b1;
        cfg_wdata = val;
        step(1);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain(input string req);
        int w = 0;
        while (exp_q.size() > 0 && w < 3000) begin
            @(negedge clk);
            w++;
        end
        check(exp_q.size() == 0, req, "expected events still pending", exp_q.size(), 0);
    endtask

    task automatic quiet(input string req);
        @(negedge clk);
        check(obs_q.size() == 0, req, "unexpected reset events", obs_q.size(), 0);
    endtask

    task automatic bus_start(output int at);
        step(1);
        sda = 1'b0;
        at = cyc;
        step(3);
        sda = 1'b1;
        step(3);
    endtask

    task automatic fake_start();
        step(1);
        scl = 1'b0;
        step(3);
        sda = 1'b0;
        step(3);
        sda = 1'b1;
        step(3);
        scl = 1'b1;
        step(3);
    endtask

    initial begin
        int s_cyc;
        int k;
        #2 por_n = 1'b0;
        step(4);
        mon_en = 1'b1;
        @(negedge clk);
        // R1 / R11: reset state while power-up is active
        check(rst_out == ACT_HIGH, "R1", "rst_out level during power-up", rst_out, ACT_HIGH);
        check(bus_inhibit == 1'b1, "R1", "bus_inhibit during power-up", bus_inhibit, 1);
        check(bus_abort == 1'b0, "R1", "bus_abort during power-up", bus_abort, 0);
        check(rst_out == 1'b0, "R11", "active-low reset level", rst_out, 0);

        // R7: write accepted, then locked write ignored
        wr_cfg(2'b00);
        check(stat_wd_sel == 2'b00, "R7", "selector after open write", stat_wd_sel, 0);
        wp = 1'b1;
        wr_cfg(2'b10);
        check(stat_wd_sel == 2'b00, "R7", "selector after locked write", stat_wd_sel, 0);
        wp = 1'b0;

        // R2, R5, R9, R12: power-up release then two unserviced timeouts
        step(1);
        por_n = 1'b1;
        supply_ok = 1'b1;
        s_cyc = cyc;
        expect_ev(EV_RELEASE, s_cyc, (H-1)*P, H*P+6, "R2");
        expect_ev(EV_ASSERT, -1, (W0-1)*P, W0*P+6, "R5");
        expect_ev(EV_ABORT, -1, 0, 0, "R9");
        expect_ev(EV_RELEASE, -1, (H-1)*P, H*P+3, "R12");
        expect_ev(EV_ASSERT, -1, (W0-1)*P, W0*P+6, "R12");
        expect_ev(EV_ABORT, -1, 0, 0, "R9");
        expect_ev(EV_RELEASE, -1, (H-1)*P, H*P+3, "R12");
        drain("R12");

        // R6: START keeps the watchdog quiet; SCL-low SDA fall does not
        wr_cfg(2'b01);
        check(stat_wd_sel == 2'b01, "R7", "selector after open write", stat_wd_sel, 1);
        bus_start(k);
        step(70);
        bus_start(k);
        step(70);
        bus_start(k);
        step(10);
        quiet("R6");
        check(rst_out != ACT_HIGH, "R6", "reset inactive while serviced", rst_out, !ACT_HIGH);
        expect_ev(EV_ASSERT, k, (W1-1)*P, W1*P+8, "R6");
        expect_ev(EV_ABORT, -1, 0, 0, "R9");
        expect_ev(EV_RELEASE, -1, (H-1)*P, H*P+3, "R12");
        step(30);
        fake_start();
        drain("R6");

        // R5: longest period
        wr_cfg(2'b10);
        expect_ev(EV_ASSERT, -1, (W2-1)*P, W2*P+6, "R5");
        expect_ev(EV_ABORT, -1, 0, 0, "R9");
        expect_ev(EV_RELEASE, -1, (H-1)*P, H*P+3, "R12");
        drain("R5");

        // R5: disabled encoding
        wr_cfg(2'b11);
        check(stat_wd_sel == 2'b11, "R7", "selector after open write", stat_wd_sel, 3);
        step(300);
        quiet("R5");
        check(rst_out != ACT_HIGH, "R5", "no timeout when disabled", rst_out, !ACT_HIGH);
        wp = 1'b1;
        wr_cfg(2'b00);
        check(stat_wd_sel == 2'b11, "R7", "selector after locked write", stat_wd_sel, 3);
        wp = 1'b0;

        // R3, R4, R10: supply drop and glitch during hold
        step(1);
        supply_ok = 1'b0;
        expect_ev(EV_ASSERT, cyc, 2, 4, "R3");
        expect_ev(EV_ABORT, -1, 0, 0, "R3");
        step(8);
        check(bus_inhibit == 1'b1, "R10", "bus_inhibit while supply low", bus_inhibit, 1);
        supply_ok = 1'b1;
        step((H/2)*P);
        supply_ok = 1'b0;
        step(10);
        supply_ok = 1'b1;
        expect_ev(EV_RELEASE, cyc, (H-1)*P, H*P+6, "R4");
        drain("R4");
        check(bus_inhibit == 1'b0, "R10", "bus_inhibit after release", bus_inhibit, 0);

        // R1, R8, R9: power-up from running, no abort, selector kept
        step(3);
        por_n = 1'b0;
        expect_ev(EV_ASSERT, cyc, 0, 1, "R1");
        step(4);
        drain("R1");
        quiet("R9");
        check(stat_wd_sel == 2'b11, "R8", "selector across power-up", stat_wd_sel, 3);
        step(1);
        por_n = 1'b1;
        expect_ev(EV_RELEASE, cyc, (H-1)*P, H*P+6, "R2");
        drain("R2");
        step(20);
        quiet("R5");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule